// File: doc/BRIEF.md
# Subpage ECC Decode Sequencer

This block drives the read of one large flash page through an external error-correction decoder. The page is handled as four subpages of 528 bytes each. Each subpage holds 512 data bytes, then 6 free spare bytes, then 10 check bytes. For each subpage the sequencer pulses a decode trigger and waits for the decoder's status byte to report the controller as ready. It then folds the decoder's verdict into a page-level result and forwards the subpage's bytes to a downstream buffer, each byte tagged with its place in the page.

A page can be read in one of two modes. A full read forwards data and spare bytes and stops at the first uncorrectable subpage with a failure. A spare-only read forwards only the spare bytes, scores an uncorrectable subpage as five errors and always runs through all four subpages. The page result is the largest per-subpage corrected count, a failure flag, a stall flag and an 8-bit status word. A programmable cycle limit bounds each wait for the decoder.

Top module: `nand_subpage_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `dec_go_o`, `out_vld_o`, `fail_o` and `stall_o` are 0, `max_err_o` is 0 and `page_status_o` is 8'h07.
- R2: A `start_i` pulse while idle starts a page. For each subpage in the order 0, 1, 2, 3, `dec_go_o` is high for exactly one cycle and `dec_sub_o` carries that subpage's index.
- R3: A decoder status with bit 3 set reports a correctable subpage with a count of bits 5:4 plus one (1 to 4). `max_err_o` is the largest count over the page's subpages, not their sum. A clean subpage counts 0.
- R4: In full-read mode (`spare_mode_i`=0), a status with bit 6 set ends the page at once: `fail_o`=1, no bytes of that subpage are taken, and no further trigger is issued.
- R5: In spare-only mode (`spare_mode_i`=1), a status with bit 6 set counts as 5 errors, `fail_o` stays 0, and all four subpages are processed.
- R6: In full-read mode, data byte k (0..511) of subpage s leaves with `out_spare_o`=0 and `out_addr_o`=s*512+k, one cycle after it is accepted.
- R7: Free byte k (0..5) of subpage s leaves with `out_spare_o`=1 and address s*6+k. Check byte k (0..9) leaves with `out_spare_o`=1 and address 24+s*10+k.
- R8: In spare-only mode, data bytes are taken from the input but never appear on the output.
- R9: Completion is status bit 1. It is accepted on wait cycles 0 through `stall_limit_i` after the trigger cycle. If it has not appeared by wait cycle `stall_limit_i`, the page ends with `stall_o`=1 and a later completion is ignored.
- R10: `page_status_o` is laid out as follows:
  - bits 2:0 are all equal to not-busy;
  - bit 3 is set when `max_err_o` is nonzero;
  - bits 5:4 are min(`max_err_o`,4)-1, or 0 when `max_err_o` is 0;
  - bit 6 is set on an uncorrectable subpage in either mode;
  - bit 7 is the stall flag.
- R11: `done_o` is a one-cycle pulse at the end of a page. The results hold until the next start. `start_i` and `spare_mode_i` changes are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Page start strobe |
| spare_mode_i | input | 1 | 1 = spare-only read, 0 = full read |
| stall_limit_i | input | TMO_W | Last wait cycle on which completion is accepted |
| dec_go_o | output | 1 | Decode trigger for one subpage |
| dec_sub_o | output | 2 | Subpage index of the current step |
| dec_status_i | input | 8 | Decoder status byte (bit1 ready, bit3 correctable, 5:4 count-1, bit6 uncorrectable) |
| in_vld_i | input | 1 | Subpage byte valid |
| in_byte_i | input | 8 | Subpage byte, in subpage order |
| out_vld_o | output | 1 | Output byte valid |
| out_spare_o | output | 1 | Output byte belongs to the 64-byte spare image |
| out_addr_o | output | 11 | Byte address in the data or spare image |
| out_byte_o | output | 8 | Output byte |
| busy_o | output | 1 | Page in progress |
| done_o | output | 1 | End-of-page pulse |
| fail_o | output | 1 | Full-read page hit an uncorrectable subpage |
| stall_o | output | 1 | Decoder completion timed out |
| max_err_o | output | 3 | Largest per-subpage error count (0..5) |
| page_status_o | output | 8 | Page status word |

## Verification
The hardest cases to reach are those where the decoder's answer lands at a chosen cycle relative to the trigger. One is completion on exactly the last allowed wait cycle. Another is completion one cycle too late, which has to be ignored. A third is an uncorrectable subpage in the middle of a page, where the two modes must part ways. The bench stub watches for each trigger and returns a status byte after a delay taken from its vector table. This places the answer on any wait cycle and lets the table vary the per-subpage verdicts. Restart and mode-flip attempts are injected in the middle of the byte stream to show that a running page is unaffected.

// File: rtl/nsq_pkg.sv
package nsq_pkg;
  localparam int NSUB     = 4;
  localparam int DATA_B   = 512;
  localparam int FREE_B   = 6;
  localparam int CHK_B    = 10;
  localparam int SUB_B    = DATA_B + FREE_B + CHK_B;
  localparam int SPARE_B  = NSUB * (FREE_B + CHK_B);
  localparam int SUB_W    = $clog2(NSUB);
  localparam int OFF_W    = $clog2(SUB_B);
  localparam int ADDR_W   = $clog2(NSUB * DATA_B);
  localparam int ERR_W    = 3;
  localparam int UNC_WEIGHT = 5;

  // status byte bit positions
  localparam int ST_NAND_RDY = 0;
  localparam int ST_CTL_RDY  = 1;
  localparam int ST_ECC_RDY  = 2;
  localparam int ST_CORR     = 3;
  localparam int ST_CNT_LO   = 4;
  localparam int ST_UNC      = 6;
  localparam int ST_STALL    = 7;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_XFER, S_FIN} seq_state_e;

  // ecc_bits = status[6:3]: [3] uncorrectable, [2:1] count-1, [0] correctable
  function automatic logic [ERR_W-1:0] sub_err_count(input logic [3:0] ecc_bits,
                                                      input logic spare);
    if (ecc_bits[3])
      return spare ? ERR_W'(UNC_WEIGHT) : '0;
    else if (ecc_bits[0])
      return ERR_W'({1'b0, ecc_bits[2:1]}) + ERR_W'(1);
    else
      return '0;
  endfunction
endpackage

// File: rtl/nsq_ctrl.sv
module nsq_ctrl
  import nsq_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             spare_i,
  input  logic [TMO_W-1:0] limit_i,
  input  logic             ready_i,
  input  logic             unc_i,
  input  logic             in_vld_i,
  output logic             dec_go_o,
  output logic [SUB_W-1:0] sub_o,
  output logic [OFF_W-1:0] off_o,
  output logic             xfer_o,
  output logic             spare_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             stall_o,
  output logic             clr_o,
  output logic             upd_o
);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(SUB_B - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(NSUB - 1);

  seq_state_e       state_q, state_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [TMO_W-1:0] timer_q, timer_d;
  logic             spare_q, spare_d;
  logic             fail_q, fail_d;
  logic             stall_q, stall_d;
  logic             clr, upd;

  always_comb begin
    state_d = state_q;
    sub_d   = sub_q;
    off_d   = off_q;
    timer_d = timer_q;
    spare_d = spare_q;
    fail_d  = fail_q;
    stall_d = stall_q;
    clr     = 1'b0;
    upd     = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_ISSUE;
          sub_d   = '0;
          spare_d = spare_i;
          fail_d  = 1'b0;
          stall_d = 1'b0;
          clr     = 1'b1;
        end
      end
      S_ISSUE: begin
        timer_d = '0;
        state_d = S_WAIT;
      end
      S_WAIT: begin
        if (ready_i) begin
          if (unc_i && !spare_q) begin
            fail_d  = 1'b1;
            state_d = S_FIN;
          end else begin
            upd     = 1'b1;
            off_d   = '0;
            state_d = S_XFER;
          end
        end else if (timer_q == limit_i) begin
          stall_d = 1'b1;
          state_d = S_FIN;
        end else begin
          timer_d = timer_q + TMO_W'(1);
        end
      end
      S_XFER: begin
        if (in_vld_i) begin
          if (off_q == OFF_LAST) begin
            if (sub_q == SUB_LAST) begin
              state_d = S_FIN;
            end else begin
              sub_d   = sub_q + SUB_W'(1);
              state_d = S_ISSUE;
            end
          end else begin
            off_d = off_q + OFF_W'(1);
          end
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sub_q   <= '0;
      off_q   <= '0;
      timer_q <= '0;
      spare_q <= 1'b0;
      fail_q  <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      off_q   <= off_d;
      timer_q <= timer_d;
      spare_q <= spare_d;
      fail_q  <= fail_d;
      stall_q <= stall_d;
    end
  end

  assign dec_go_o = (state_q == S_ISSUE);
  assign sub_o    = sub_q;
  assign off_o    = off_q;
  assign xfer_o   = (state_q == S_XFER) && in_vld_i;
  assign spare_o  = spare_q;
  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_FIN);
  assign fail_o   = fail_q;
  assign stall_o  = stall_q;
  assign clr_o    = clr;
  assign upd_o    = upd;

  a_r2_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_go_o |=> !dec_go_o);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r4_abort_now: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && ready_i && unc_i && !spare_q) |=> (done_o && fail_o && !stall_o));
  a_r9_stall_end: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && !ready_i && timer_q == limit_i) |=> (done_o && stall_o));
  a_r9_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_o && stall_o));
endmodule

// File: rtl/nsq_err_merge.sv
module nsq_err_merge
  import nsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             spare_i,
  input  logic [3:0]       ecc_bits_i,
  output logic [ERR_W-1:0] max_o
);
  logic [ERR_W-1:0] max_q, max_d, sub_cnt;

  assign sub_cnt = sub_err_count(ecc_bits_i, spare_i);

  always_comb begin
    max_d = max_q;
    if (clr_i)
      max_d = '0;
    else if (upd_i && (sub_cnt > max_q))
      max_d = sub_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) max_q <= '0;
    else        max_q <= max_d;
  end

  assign max_o = max_q;

  a_r3_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (max_o >= $past(max_o)));
  a_r3_covers_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !clr_i) |=> (max_o >= $past(sub_cnt)));
  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    max_o <= ERR_W'(UNC_WEIGHT));
endmodule

// File: rtl/nsq_spare_map.sv
module nsq_spare_map
  import nsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic              spare_mode_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [7:0]        byte_i,
  output logic              out_vld_o,
  output logic              out_spare_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [7:0]        out_byte_o
);
  localparam int DB_W = $clog2(DATA_B);

  logic [ADDR_W-1:0] data_addr, free_addr, chk_addr, addr_d;
  logic              in_data, in_free, keep, spare_d;

  generate
    if ((1 << DB_W) == DATA_B) begin : g_pow2
      assign data_addr = ADDR_W'({sub_i, off_i[DB_W-1:0]});
    end else begin : g_mul
      assign data_addr = ADDR_W'(int'(sub_i) * DATA_B + int'(off_i));
    end
  endgenerate

  assign free_addr = ADDR_W'(int'(sub_i) * FREE_B + int'(off_i) - DATA_B);
  assign chk_addr  = ADDR_W'(NSUB * FREE_B + int'(sub_i) * CHK_B
                             + int'(off_i) - DATA_B - FREE_B);

  always_comb begin
    in_data = (off_i < OFF_W'(DATA_B));
    in_free = !in_data && (off_i < OFF_W'(DATA_B + FREE_B));
    keep    = vld_i && !(in_data && spare_mode_i);
    spare_d = !in_data;
    if (in_data)      addr_d = data_addr;
    else if (in_free) addr_d = free_addr;
    else              addr_d = chk_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_o   <= 1'b0;
      out_spare_o <= 1'b0;
      out_addr_o  <= '0;
      out_byte_o  <= '0;
    end else begin
      out_vld_o <= keep;
      if (keep) begin
        out_spare_o <= spare_d;
        out_addr_o  <= addr_d;
        out_byte_o  <= byte_i;
      end
    end
  end

  a_r7_spare_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_o && out_spare_o) |-> (out_addr_o < ADDR_W'(SPARE_B)));
  a_r8_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && spare_mode_i) |=> (!out_vld_o || out_spare_o));
endmodule

// File: rtl/nand_subpage_seq.sv
module nand_subpage_seq
  import nsq_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              spare_mode_i,
  input  logic [TMO_W-1:0]  stall_limit_i,
  output logic              dec_go_o,
  output logic [SUB_W-1:0]  dec_sub_o,
  input  logic [7:0]        dec_status_i,
  input  logic              in_vld_i,
  input  logic [7:0]        in_byte_i,
  output logic              out_vld_o,
  output logic              out_spare_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [7:0]        out_byte_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              stall_o,
  output logic [ERR_W-1:0]  max_err_o,
  output logic [7:0]        page_status_o
);
  logic [OFF_W-1:0] off;
  logic             xfer, spare_q, clr, upd;
  logic             unused_status_bits;

  assign unused_status_bits = ^{dec_status_i[ST_NAND_RDY], dec_status_i[ST_ECC_RDY],
                                dec_status_i[ST_STALL]};

  nsq_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .spare_i  (spare_mode_i),
    .limit_i  (stall_limit_i),
    .ready_i  (dec_status_i[ST_CTL_RDY]),
    .unc_i    (dec_status_i[ST_UNC]),
    .in_vld_i (in_vld_i),
    .dec_go_o (dec_go_o),
    .sub_o    (dec_sub_o),
    .off_o    (off),
    .xfer_o   (xfer),
    .spare_o  (spare_q),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .fail_o   (fail_o),
    .stall_o  (stall_o),
    .clr_o    (clr),
    .upd_o    (upd)
  );

  nsq_err_merge u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .upd_i      (upd),
    .spare_i    (spare_q),
    .ecc_bits_i (dec_status_i[ST_UNC:ST_CORR]),
    .max_o      (max_err_o)
  );

  nsq_spare_map u_map (
    .clk          (clk),
    .rst_n        (rst_n),
    .vld_i        (xfer),
    .spare_mode_i (spare_q),
    .sub_i        (dec_sub_o),
    .off_i        (off),
    .byte_i       (in_byte_i),
    .out_vld_o    (out_vld_o),
    .out_spare_o  (out_spare_o),
    .out_addr_o   (out_addr_o),
    .out_byte_o   (out_byte_o)
  );

  always_comb begin
    page_status_o = '0;
    page_status_o[ST_NAND_RDY] = !busy_o;
    page_status_o[ST_CTL_RDY]  = !busy_o;
    page_status_o[ST_ECC_RDY]  = !busy_o;
    page_status_o[ST_CORR]     = (max_err_o != '0);
    if (max_err_o == '0)
      page_status_o[ST_CNT_LO +: 2] = 2'd0;
    else if (max_err_o >= ERR_W'(4))
      page_status_o[ST_CNT_LO +: 2] = 2'd3;
    else
      page_status_o[ST_CNT_LO +: 2] = 2'(max_err_o - ERR_W'(1));
    page_status_o[ST_UNC]   = fail_o || (max_err_o == ERR_W'(UNC_WEIGHT));
    page_status_o[ST_STALL] = stall_o;
  end

  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (page_status_o[ST_CTL_RDY] && !busy_o));
  a_r11_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(max_err_o) && $stable(fail_o) && $stable(stall_o)));
endmodule

// File: tb/nand_subpage_seq_bench.sv
module nand_subpage_seq_bench;
  localparam int TMO_W = 16;

  typedef struct packed {
    logic       mode;
    logic [7:0] s0, s1, s2, s3;
    logic [3:0] delay;
    logic [7:0] limit;
    logic       poke;
  } vec_t;

  // status codes without the ready bit: 08/18/28/38 = 1..4 corrected, 40 = uncorrectable
  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 4'd1, 8'd16, 1'b0},
    '{1'b0, 8'h08, 8'h28, 8'h18, 8'h00, 4'd2, 8'd16, 1'b0},
    '{1'b0, 8'h38, 8'h08, 8'h38, 8'h18, 4'd1, 8'd16, 1'b1},
    '{1'b0, 8'h18, 8'h40, 8'h00, 8'h00, 4'd3, 8'd16, 1'b0},
    '{1'b1, 8'h08, 8'h40, 8'h18, 8'h00, 4'd1, 8'd16, 1'b0},
    '{1'b1, 8'h00, 8'h00, 8'h28, 8'h00, 4'd2, 8'd16, 1'b1},
    '{1'b0, 8'h40, 8'h00, 8'h00, 8'h00, 4'd1, 8'd16, 1'b0},
    '{1'b0, 8'h08, 8'h00, 8'h00, 8'h18, 4'd5, 8'd4,  1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             spare_mode = 1'b0;
  logic [TMO_W-1:0] stall_limit = 16'd16;
  logic [7:0]       dec_status = 8'h00;
  logic             in_vld = 1'b0;
  logic [7:0]       in_byte = 8'h00;
  logic             dec_go, out_vld, out_spare, busy, done, fail, stall;
  logic [1:0]       dec_sub;
  logic [10:0]      out_addr;
  logic [7:0]       out_byte;
  logic [2:0]       max_err;
  logic [7:0]       page_status;

  int n_chk = 0;
  int n_fail = 0;

  logic [19:0] exp_mem [4096];
  int wr_ptr = 0;
  int rd_ptr = 0;
  int mon_err = 0;
  int go_cnt = 0;

  always #10 clk = ~clk;

  nand_subpage_seq #(.TMO_W(TMO_W)) u_nand_subpage_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .spare_mode_i  (spare_mode),
    .stall_limit_i (stall_limit),
    .dec_go_o      (dec_go),
    .dec_sub_o     (dec_sub),
    .dec_status_i  (dec_status),
    .in_vld_i      (in_vld),
    .in_byte_i     (in_byte),
    .out_vld_o     (out_vld),
    .out_spare_o   (out_spare),
    .out_addr_o    (out_addr),
    .out_byte_o    (out_byte),
    .busy_o        (busy),
    .done_o        (done),
    .fail_o        (fail),
    .stall_o       (stall),
    .max_err_o     (max_err),
    .page_status_o (page_status)
  );

  // output monitor: compares every emitted byte with the expected list
  always @(negedge clk) begin
    if (dec_go) go_cnt <= go_cnt + 1;
    if (out_vld) begin
      if (rd_ptr == wr_ptr) mon_err <= mon_err + 1;
      else begin
        if (exp_mem[rd_ptr % 4096] != {out_spare, out_addr, out_byte}) mon_err <= mon_err + 1;
        rd_ptr <= rd_ptr + 1;
      end
    end
  end

  initial begin
    #(20 * 190000);
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pick(input vec_t v, input int s);
    case (s)
      0: return v.s0;
      1: return v.s1;
      2: return v.s2;
      default: return v.s3;
    endcase
  endfunction

  function automatic logic [7:0] exp_status(input int mx, input bit f, input bit st);
    logic [7:0] w;
    w = 8'h07;
    if (mx != 0) w[3] = 1'b1;
    w[5:4] = (mx == 0) ? 2'd0 : (mx >= 4) ? 2'd3 : 2'(mx - 1);
    w[6] = f || (mx == 5);
    w[7] = st;
    return w;
  endfunction

  task automatic wait_go(output bit ok);
    int n;
    n = 0;
    while (!dec_go && n < 200) begin @(negedge clk); n++; end
    ok = dec_go;
  endtask

  task automatic wait_done(output bit ok);
    int n;
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    ok = done;
  endtask

  task automatic run_page(input vec_t v, input int vi);
    int  exp_max, issued, go0, err0, trig_err, cnt;
    bit  exp_fail, ok;
    logic [7:0] st;
    exp_max = 0; exp_fail = 0; issued = 0; trig_err = 0;
    go0 = go_cnt; err0 = mon_err;
    stall_limit = TMO_W'(v.limit);
    spare_mode  = v.mode;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int s = 0; s < 4; s++) begin
      wait_go(ok);
      if (!ok) begin
        chk(0, "R2", "trigger missing", s, s);
        return;
      end
      issued++;
      if (dec_sub != 2'(s)) trig_err++;
      st = pick(v, s) | 8'h02;
      repeat (v.delay) @(negedge clk);
      dec_status = st;
      @(negedge clk);
      dec_status = 8'h00;
      if (st[6] && !v.mode) begin
        exp_fail = 1'b1;
        break;
      end
      cnt = st[6] ? 5 : st[3] ? int'(st[5:4]) + 1 : 0;
      if (cnt > exp_max) exp_max = cnt;
      for (int off = 0; off < 528; off++) begin
        in_vld  = 1'b1;
        in_byte = 8'((s * 528 + off) * 7 + vi);
        if (off < 512) begin
          if (!v.mode) begin
            exp_mem[wr_ptr % 4096] = {1'b0, 11'(s * 512 + off), in_byte};
            wr_ptr++;
          end
        end else if (off < 518) begin
          exp_mem[wr_ptr % 4096] = {1'b1, 11'(s * 6 + off - 512), in_byte};
          wr_ptr++;
        end else begin
          exp_mem[wr_ptr % 4096] = {1'b1, 11'(24 + s * 10 + off - 518), in_byte};
          wr_ptr++;
        end
        // R11: restart and mode flip attempts while busy
        start      = v.poke && s == 1 && off == 100;
        spare_mode = (v.poke && s == 1 && off == 100) ? ~v.mode : v.mode;
        @(negedge clk);
      end
      in_vld = 1'b0;
      start = 1'b0;
      spare_mode = v.mode;
    end
    wait_done(ok);
    chk(ok, "R11", $sformatf("vec%0d done seen", vi), ok, 1);
    chk(fail == exp_fail, exp_fail ? "R4" : "R5", $sformatf("vec%0d fail", vi), fail, exp_fail);
    chk(max_err == 3'(exp_max), v.mode ? "R5" : "R3", $sformatf("vec%0d max", vi), max_err, exp_max);
    @(negedge clk);
    chk(!done, "R11", $sformatf("vec%0d done pulse", vi), done, 0);
    chk(page_status == exp_status(exp_max, exp_fail, 0), "R10",
        $sformatf("vec%0d status", vi), page_status, exp_status(exp_max, exp_fail, 0));
    chk(rd_ptr == wr_ptr && mon_err == err0, v.mode ? "R8" : "R6",
        $sformatf("vec%0d stream mismatches (R7)", vi), mon_err - err0 + (wr_ptr - rd_ptr), 0);
    chk(go_cnt - go0 == issued && trig_err == 0, exp_fail ? "R4" : "R2",
        $sformatf("vec%0d triggers", vi), go_cnt - go0, issued);
    repeat (10) @(negedge clk);
    chk(max_err == 3'(exp_max) && fail == exp_fail && !busy, "R11",
        $sformatf("vec%0d held", vi), max_err, exp_max);
  endtask

  initial begin
    bit ok, seen;
    int go0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !dec_go && !out_vld && !fail && !stall && max_err == 0,
        "R1", "reset outputs idle", {busy, done, dec_go, out_vld, fail, stall}, 0);
    chk(page_status == 8'h07, "R1", "reset status", page_status, 8'h07);
    rst_n = 1'b1;
    @(negedge clk);
    chk(page_status == 8'h07 && !busy, "R1", "status after release", page_status, 8'h07);

    for (int i = 0; i < NVEC; i++) run_page(VECS[i], i);

    // R9: decoder never answers
    stall_limit = 16'd4;
    spare_mode  = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_go(ok);
    wait_done(ok);
    chk(ok && stall && !fail, "R9", "stall on silence", stall, 1);
    @(negedge clk);
    chk(page_status == 8'h87, "R10", "stall status", page_status, 8'h87);

    // R9: completion one cycle past the limit is ignored
    go0 = go_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_go(ok);
    seen = 1'b0;
    for (int d = 0; d < 6; d++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    dec_status = 8'h02;
    @(negedge clk);
    dec_status = 8'h00;
    repeat (4) @(negedge clk);
    chk(seen && stall && !busy, "R9", "late completion stalls", stall, 1);
    chk(go_cnt - go0 == 1, "R9", "late completion ignored", go_cnt - go0, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule